// File: doc/BRIEF.md
# Set-Associative Read Cache with Selectable Victim Policy

The block is a small read-only cache that sits between a requester and a word-addressed backing memory. It holds four sets of two ways, and each line carries four 16-bit words. A request address is broken into three fields: the high bits form the tag, the middle bits pick the set, and the low bits pick the word inside the block. Because the set bits sit directly above the offset, the set a block lands in is its block number taken modulo the set count. Within that set, the block may occupy either way.

A lookup compares the stored tags of the indexed set. A match returns the word on the next cycle. A miss reads the whole block from the backing memory one word at a time, writes it into a chosen way, and then returns the requested word. Empty ways are used before any valid line is replaced. When both ways are valid, a build-time parameter picks one of three victim rules:
- least recently used;
- oldest fill;
- a pseudo-random choice.

Both data interfaces apply back-pressure:
- A request is taken only when `req_valid` and `req_ready` are high on the same clock edge. `req_ready` is high only when no lookup, fill or response is outstanding.
- A response remains on the outputs until `rsp_ready` accepts it.
- The memory port raises `mem_req` with a stable `mem_addr`. Each `mem_ack` pulse delivers the word for that address on `mem_rdata`.

Top module: `sa_cache`

## Requirements
- R1: A 12-bit word address is decoded as follows:
  - offset = bits [1:0];
  - set = bits [3:2], which equals the block number (bits [11:2]) modulo 4;
  - tag = bits [11:4].
  Blocks in different sets never displace each other.
- R2: On a tag match, `rsp_valid` rises on the cycle after acceptance. No memory request is made, and `rsp_data` holds the stored word for the requested offset.
- R3: On a miss, the cache reads the four words of the block at addresses {tag, set, 0..3} in ascending offset order, starting at offset 0. It then raises `rsp_valid` on the cycle after the last word is acknowledged, with the requested word on `rsp_data`.
- R4: While the indexed set has an invalid way, a fill goes to the lowest-numbered invalid way. No valid line is evicted in that case.
- R5: With the least-recently-used rule, the victim is the way whose last hit or fill is the oldest.
- R6: With the oldest-fill rule, the victim is the way that was filled earliest. Later hits do not change this choice.
- R7: With the random rule, the victim comes from the low bit of a free-running 8-bit LFSR with taps x^8+x^6+x^5+x^4+1. No usage history is kept, and across repeated conflicts either way can be evicted.
- R8: `req_ready` is high only in the idle state. A fill starts only after a request has been accepted.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` does not change.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` does not change.
- R11: Reset leaves the cache with:
  - every line invalid;
  - the policy state in its initial order;
  - `req_ready` high, and `rsp_valid` and `mem_req` low.
  As a result, the first access to each set after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request is present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | Response word is present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Response word |
| mem_req | output | 1 | Backing-memory read request |
| mem_addr | output | ADDR_W | Backing-memory word address |
| mem_ack | input | 1 | Memory delivers the word for mem_addr |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The assertions check the following on every cycle:
- the handshake rules: stable response and stable memory address under back-pressure, and no fill without an accepted request;
- the structure of a fill: it starts at offset 0, the address steps by one per acknowledged word, and the response follows the final word;
- the hit path: an accepted request leads to either a response or a memory request on the next cycle.

Whether a request should have hit depends on what is resident, so the bench keeps its own model of tags and victim order. It runs directed conflict sequences and random traffic against that model. Only those scenarios can show:
- which line each policy evicts;
- that empty ways fill first;
- that returned words match memory;
- that the random rule really evicts both ways.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_RAND = 2'd2
  } repl_pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RESP = 2'd2
  } cstate_e;

endpackage

// File: rtl/sa_cache_store.sv
module sa_cache_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup port
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [OFF_W-1:0]  lk_off,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [DATA_W-1:0] hit_data,
  output logic [WAYS-1:0]   set_valid,
  // fill port
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [TAG_W-1:0]  commit_tag
);

  logic [DATA_W-1:0] words_q [SETS][WAYS][WORDS];
  logic [TAG_W-1:0]  tags_q  [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) words_q[wr_set][wr_way][wr_off] <= wr_data;
    if (commit) tags_q[wr_set][wr_way] <= commit_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (commit) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_set][w] && tags_q[lk_set][w] == lk_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  assign hit_data  = words_q[lk_set][hit_way][lk_off];
  assign set_valid = valid_q[lk_set];

endmodule

// File: rtl/sa_cache_victim.sv
module sa_cache_victim
  import sa_cache_pkg::*;
#(
  parameter int        SETS   = 4,
  parameter int        WAYS   = 2,
  parameter repl_pol_e POLICY = POL_LRU,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] q_set,
  input  logic [WAYS-1:0]  set_valid,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim_way
);

  logic [WAY_W-1:0] pol_way;
  logic [WAY_W-1:0] inv_way;
  logic             inv_found;

  // lowest-numbered empty way wins over any policy choice
  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  assign victim_way = inv_found ? inv_way : pol_way;

  generate
    if (POLICY == POL_LRU) begin : g_lru
      // per-way age rank: 0 = most recent, WAYS-1 = oldest
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic             acc_en;
      logic [SET_W-1:0] acc_set;
      logic [WAY_W-1:0] acc_way;

      assign acc_en  = touch_en | fill_en;
      assign acc_set = fill_en ? fill_set : touch_set;
      assign acc_way = fill_en ? fill_way : touch_way;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
              age_q[s][w] <= WAY_W'(w);
        end else if (acc_en) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == acc_way)
              age_q[acc_set][w] <= '0;
            else if (age_q[acc_set][w] < age_q[acc_set][acc_way])
              age_q[acc_set][w] <= age_q[acc_set][w] + 1'b1;
          end
        end
      end

      always_comb begin
        pol_way = '0;
        for (int w = 0; w < WAYS; w++)
          if (age_q[q_set][w] == WAY_W'(WAYS - 1)) pol_way = WAY_W'(w);
      end
    end else if (POLICY == POL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] ptr_q [SETS];
      logic             unused_fifo;

      assign unused_fifo = ^{touch_en, touch_set, touch_way};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (fill_en) begin
          ptr_q[fill_set] <= (fill_way == WAY_W'(WAYS - 1)) ? '0 : fill_way + 1'b1;
        end
      end

      assign pol_way = ptr_q[q_set];
    end else begin : g_rand
      logic [7:0] lfsr_q;
      logic       unused_rand;

      assign unused_rand = ^{q_set, touch_en, touch_set, touch_way,
                             fill_en, fill_set, fill_way};

      always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 8'hA5;
        else        lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
      end

      assign pol_way = lfsr_q[WAY_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int        ADDR_W = 12,
  parameter int        DATA_W = 16,
  parameter int        SETS   = 4,
  parameter int        WAYS   = 2,
  parameter int        WORDS  = 4,
  parameter repl_pol_e POLICY = POL_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  cstate_e           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [WAY_W-1:0]  vic_q;
  logic [DATA_W-1:0] rsp_q;

  logic [SET_W-1:0]  lk_set, q_set;
  logic [TAG_W-1:0]  lk_tag, q_tag;
  logic [OFF_W-1:0]  lk_off, q_off;

  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [DATA_W-1:0] hit_data;
  logic [WAYS-1:0]   set_valid;
  logic [WAY_W-1:0]  victim_way;

  logic accept, beat, last_beat;

  assign lk_off = req_addr[OFF_W-1:0];
  assign lk_set = req_addr[OFF_W +: SET_W];
  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign q_off  = addr_q[OFF_W-1:0];
  assign q_set  = addr_q[OFF_W +: SET_W];
  assign q_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rsp_q;
  assign mem_req   = (state_q == ST_FILL);
  assign mem_addr  = {q_tag, q_set, cnt_q};

  assign accept    = req_valid && req_ready;
  assign beat      = mem_req && mem_ack;
  assign last_beat = beat && (cnt_q == LAST_OFF);

  sa_cache_store #(
    .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (lk_set),
    .lk_tag    (lk_tag),
    .lk_off    (lk_off),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_data  (hit_data),
    .set_valid (set_valid),
    .wr_en     (beat),
    .wr_set    (q_set),
    .wr_way    (vic_q),
    .wr_off    (cnt_q),
    .wr_data   (mem_rdata),
    .commit    (last_beat),
    .commit_tag(q_tag)
  );

  sa_cache_victim #(
    .SETS(SETS), .WAYS(WAYS), .POLICY(POLICY)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_set     (lk_set),
    .set_valid (set_valid),
    .touch_en  (accept && hit),
    .touch_set (lk_set),
    .touch_way (hit_way),
    .fill_en   (last_beat),
    .fill_set  (q_set),
    .fill_way  (vic_q),
    .victim_way(victim_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      vic_q   <= '0;
      rsp_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr;
          if (hit) begin
            rsp_q   <= hit_data;
            state_q <= ST_RESP;
          end else begin
            vic_q   <= victim_way;
            cnt_q   <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ack) begin
          if (cnt_q == q_off) rsp_q <= mem_rdata;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_OFF) state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);

  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R3
  fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr[OFF_W-1:0] == '0);

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_addr[OFF_W-1:0] != LAST_OFF
      |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_addr[OFF_W-1:0] == LAST_OFF |=> rsp_valid && !mem_req);

  // R8
  accept_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(req_valid && req_ready));

  // R2
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid ^ mem_req);

endmodule

bind sa_cache sa_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack)
);

// File: tb/sa_cache_bench.sv
module sa_cache_bench;
  import sa_cache_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100000;
  localparam int N          = 3;   // 0: LRU, 1: FIFO, 2: random

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        req_valid [N];
  logic        req_ready [N];
  logic [11:0] req_addr  [N];
  logic        rsp_valid [N];
  logic        rsp_ready [N];
  logic [15:0] rsp_data  [N];
  logic        mem_req   [N];
  logic [11:0] mem_addr  [N];
  logic        mem_ack   [N];
  logic [15:0] mem_rdata [N];

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_dut
      sa_cache #(
        .POLICY(k == 0 ? POL_LRU : (k == 1 ? POL_FIFO : POL_RAND))
      ) u_sa_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[k]), .req_ready(req_ready[k]), .req_addr(req_addr[k]),
        .rsp_valid(rsp_valid[k]), .rsp_ready(rsp_ready[k]), .rsp_data(rsp_data[k]),
        .mem_req(mem_req[k]), .mem_addr(mem_addr[k]),
        .mem_ack(mem_ack[k]), .mem_rdata(mem_rdata[k])
      );
    end
  endgenerate

  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [15:0] memf(input logic [11:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'd40503;
    return p[15:0] ^ 16'h3C5A;
  endfunction

  function automatic logic [11:0] mk(input int t, input int s, input int o);
    return {8'(t), 2'(s), 2'(o)};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // backing memory model: variable wait, one-cycle ack, order and hold tracking
  int          ack_cnt   [N] = '{0, 0, 0};
  int          order_err [N] = '{0, 0, 0};
  int          hold_err  [N] = '{0, 0, 0};
  int          wcnt      [N] = '{0, 0, 0};
  bit          pend      [N] = '{0, 0, 0};
  logic [11:0] hold_addr [N];
  logic [9:0]  exp_blk   [N];

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        mem_ack[i]   <= 1'b0;
        mem_rdata[i] <= '0;
        wcnt[i]      <= 0;
        pend[i]      <= 1'b0;
      end else if (mem_ack[i]) begin
        mem_ack[i] <= 1'b0;
      end else if (mem_req[i]) begin
        if (pend[i] && mem_addr[i] != hold_addr[i]) hold_err[i] <= hold_err[i] + 1;
        if (wcnt[i] != 0) begin
          wcnt[i]      <= wcnt[i] - 1;
          pend[i]      <= 1'b1;
          hold_addr[i] <= mem_addr[i];
        end else begin
          mem_ack[i]   <= 1'b1;
          mem_rdata[i] <= memf(mem_addr[i]);
          pend[i]      <= 1'b0;
          if (mem_addr[i][1:0] != 2'(ack_cnt[i]) || mem_addr[i][11:2] != exp_blk[i])
            order_err[i] <= order_err[i] + 1;
          ack_cnt[i] <= ack_cnt[i] + 1;
          wcnt[i]    <= (ack_cnt[i] + int'(mem_addr[i][3:2])) % 3;
        end
      end
    end
  end

  // reference model of residency for the LRU and FIFO instances
  bit         mv    [N][4][2];
  logic [7:0] mt    [N][4][2];
  int         mold  [N][4];
  int         mptr  [N][4];

  task automatic model_acc(input int i, input logic [11:0] a, output bit hit);
    int s, hw, v;
    s = int'(a[3:2]);
    hit = 1'b0;
    hw = 0;
    for (int w = 0; w < 2; w++)
      if (mv[i][s][w] && mt[i][s][w] == a[11:4]) begin hit = 1'b1; hw = w; end
    if (hit) begin
      mold[i][s] = 1 - hw;
    end else begin
      if (!mv[i][s][0])      v = 0;
      else if (!mv[i][s][1]) v = 1;
      else                   v = (i == 0) ? mold[i][s] : mptr[i][s];
      mv[i][s][v] = 1'b1;
      mt[i][s][v] = a[11:4];
      mold[i][s]  = 1 - v;
      mptr[i][s]  = 1 - v;
    end
  endtask

  task automatic do_req(input int i, input logic [11:0] a,
                        output logic [15:0] d, output int lat, output int nm);
    int  n0;
    bit  busy_ready;
    exp_blk[i] = a[11:2];
    @(negedge clk);
    while (!req_ready[i]) @(negedge clk);
    req_valid[i] = 1'b1;
    req_addr[i]  = a;
    n0 = ack_cnt[i];
    @(negedge clk);
    req_valid[i] = 1'b0;
    lat = 1;
    busy_ready = 1'b0;
    while (!rsp_valid[i]) begin
      if (req_ready[i]) busy_ready = 1'b1;
      @(negedge clk);
      lat++;
    end
    if (req_ready[i]) busy_ready = 1'b1;
    chk(!busy_ready, "R8 ready while busy", int'(busy_ready), 0);
    d  = rsp_data[i];
    nm = ack_cnt[i] - n0;
  endtask

  task automatic access(input int i, input logic [11:0] a, input string lbl, output bit was_hit);
    bit          mh;
    logic [15:0] d;
    int          lat, nm;
    mh = 1'b0;
    if (i != 2) model_acc(i, a, mh);
    do_req(i, a, d, lat, nm);
    was_hit = (nm == 0);
    chk(d == memf(a), was_hit ? "R2 hit data" : "R3 miss data", int'(d), int'(memf(a)));
    if (was_hit) chk(lat == 1, "R2 hit latency", lat, 1);
    else         chk(nm == 4, "R3 words per fill", nm, 4);
    if (i != 2) chk(was_hit == mh, lbl, int'(was_hit), int'(mh));
  endtask

  task automatic run_all();
    bit  h;
    int  rh, rm;
    logic [15:0] d0;
    bit  held;

    // R11: reset state at the ports
    for (int i = 0; i < N; i++)
      chk(req_ready[i] && !rsp_valid[i] && !mem_req[i], "R11 reset outputs",
          int'({req_ready[i], rsp_valid[i], mem_req[i]}), 4);
    for (int i = 0; i < N; i++) begin
      access(i, mk(7, 0, 1), "R11 first access", h);
      chk(!h, "R11 first access misses", int'(h), 0);
    end

    // R5: LRU conflict in set 1
    access(0, mk(1, 1, 0), "R5 fill A", h);
    access(0, mk(2, 1, 3), "R4 fill B", h);
    access(0, mk(1, 1, 2), "R5 hit A", h);
    access(0, mk(3, 1, 1), "R5 C evicts B", h);
    access(0, mk(1, 1, 1), "R5 A kept", h);
    chk(h, "R5 recently used line kept", int'(h), 1);
    access(0, mk(2, 1, 0), "R5 B evicted", h);
    chk(!h, "R5 least recent evicted", int'(h), 0);

    // R6: FIFO conflict in set 2, hit on A must not protect it
    access(1, mk(1, 2, 0), "R6 fill A", h);
    access(1, mk(2, 2, 1), "R6 fill B", h);
    access(1, mk(1, 2, 3), "R6 hit A", h);
    access(1, mk(3, 2, 2), "R6 C evicts A", h);
    access(1, mk(1, 2, 0), "R6 A evicted", h);
    chk(!h, "R6 earliest fill evicted", int'(h), 0);

    // R4: random instance, two fills into an empty set must both survive
    access(2, mk(4, 1, 0), "R4", h);
    access(2, mk(5, 1, 2), "R4", h);
    access(2, mk(4, 1, 3), "R4", h);
    chk(h, "R4 first fill kept", int'(h), 1);
    access(2, mk(5, 1, 1), "R4", h);
    chk(h, "R4 second fill kept", int'(h), 1);

    // R1: same tag in all four sets coexists
    for (int s = 0; s < 4; s++) access(0, mk(9, s, s), "R1 load", h);
    for (int s = 0; s < 4; s++) begin
      access(0, mk(9, s, 3 - s), "R1 set decode", h);
      chk(h, "R1 distinct sets kept", int'(h), 1);
    end

    // R7: random victim hits both ways over repeated conflicts
    rh = 0; rm = 0;
    for (int t = 0; t < 24; t++) begin
      access(2, mk(10 + 3 * t, 3, 0), "R7", h);
      access(2, mk(11 + 3 * t, 3, 1), "R7", h);
      access(2, mk(12 + 3 * t, 3, 2), "R7", h);
      access(2, mk(10 + 3 * t, 3, 3), "R7", h);
      if (h) rh++; else rm++;
    end
    chk(rh > 0 && rm > 0, "R7 both ways evicted", rh, 1);

    // R9: back-pressure on a hit response
    begin
      bit mh;
      model_acc(0, mk(9, 2, 0), mh);
      rsp_ready[0] = 1'b0;
      @(negedge clk);
      req_valid[0] = 1'b1;
      req_addr[0]  = mk(9, 2, 0);
      @(negedge clk);
      req_valid[0] = 1'b0;
      d0 = rsp_data[0];
      held = rsp_valid[0];
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (!rsp_valid[0] || rsp_data[0] != d0 || req_ready[0]) held = 1'b0;
      end
      chk(held, "R9 response held", int'(held), 1);
      chk(d0 == memf(mk(9, 2, 0)), "R9 held data", int'(d0), int'(memf(mk(9, 2, 0))));
      rsp_ready[0] = 1'b1;
      @(negedge clk);
      chk(!rsp_valid[0] && req_ready[0], "R9 released", int'(rsp_valid[0]), 0);
    end

    // random traffic against the model
    for (int i = 0; i < 2; i++)
      for (int n = 0; n < 150; n++)
        access(i, mk(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4)),
               i == 0 ? "R5 random traffic" : "R6 random traffic", h);

    for (int i = 0; i < N; i++) begin
      chk(order_err[i] == 0, "R3 fill order", order_err[i], 0);
      chk(hold_err[i] == 0, "R10 memory hold", hold_err[i], 0);
    end
  endtask

  initial begin
    bit wd;
    void'($urandom(32'd1357));
    wd = 1'b0;
    for (int i = 0; i < N; i++) begin
      req_valid[i] = 1'b0;
      req_addr[i]  = '0;
      rsp_ready[i] = 1'b1;
      exp_blk[i]   = '0;
      for (int s = 0; s < 4; s++) begin
        mold[i][s] = 0;
        mptr[i][s] = 0;
        for (int w = 0; w < 2; w++) begin mv[i][s][w] = 1'b0; mt[i][s][w] = '0; end
      end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule